// File: doc/BRIEF.md
# Dirty Eviction Writeback Tracker

This block follows one dirty cache line from the moment it is pushed out of a shared cache to the moment its data reaches memory. When a line held modified or owned is replaced, the tracker copies the line's address, data, dirty bit and an owned-implies-shared flag into a single-entry buffer. It then raises a dirty-victim request toward the directory and waits for the memory writeback acknowledge. When that acknowledge arrives it emits the buffered data and frees the buffer. Clean lines (exclusive, shared or invalid) are dropped on replacement with no traffic.

While an eviction is in flight, other agents can race with it. A new victim for the same line can arrive from an upper-level cache. A probe-invalidate can cancel the writeback or make the buffered copy stale. The sender of a late victim can cancel it. Seven internal states sequence these races. Stale data is never written to memory. Late victim data is either dropped, or adopted when the buffered copy has been invalidated. Every late victim is unblocked exactly once.

Only one eviction is tracked. A replace request that arrives while the buffer is busy is held off by deasserting the ready output until the buffer is freed. All request and data events are single-cycle strobes qualified by an address that must match the buffered line. All outputs are registered single-cycle pulses.

Top module: `wbt_evict_tracker`

## Requirements
- R1: After reset `repl_ready` is 1, and every output strobe (`vreq_valid`, `wb_valid`, `mcancel_valid`, `unblock_valid`, `req_ack`, `req_retry`, `free_valid`) is 0.
- R2: The line-state encoding on `repl_state` is 0 invalid, 1 shared, 2 exclusive, 3 owned, 4 modified. A replace accepted (`repl_valid` and `repl_ready` at a clock edge) with state 3 or 4 pulses `vreq_valid` with `vreq_addr` equal to the replaced address after that edge, and `repl_ready` is then 0.
- R3: A replace accepted with state 0, 1 or 2 produces no output strobe, and `repl_ready` stays 1.
- R4: While waiting for the acknowledge with no late victim, a matching `ack_valid` pulses `wb_valid` and `free_valid` together. The write carries the buffered data and dirty bit. `wb_shared` is 1 exactly when the line was replaced from the owned state. `repl_ready` returns to 1.
- R5: A matching victim request (`req_cancel`=0) while waiting pulses `req_ack` and records `req_src`. If the acknowledge comes next, the buffered data is written back with no free. The late victim's data is then discarded, and `unblock_valid` and `free_valid` pulse together.
- R6: With a late victim recorded, its data or a cancel (`req_cancel`=1) whose `req_src` matches the recorded source pulses `unblock_valid` and resumes waiting for the acknowledge. A cancel from any other source pulses `req_retry`.
- R7: A matching probe-invalidate while a late victim is recorded marks the buffer stale. If the victim data then arrives before the acknowledge, it replaces the buffered data and dirty bit, pulses `unblock_valid`, and the next acknowledge writes it back and frees the buffer. If the acknowledge arrives first, nothing is emitted. The later victim data is then written back directly with `unblock_valid` and `free_valid`.
- R8: A matching probe-invalidate while waiting with no late victim pulses `mcancel_valid` with the buffered address. Victim data is then ignored. The next acknowledge pulses only `free_valid`, with no writeback.
- R9: Every writeback reports `wb_cstate` equal to 1 (the shared code), and `wb_addr` equal to the buffered address.
- R10: A victim request in any busy state other than plain waiting pulses `req_retry`. A request whose address differs from the buffered line, or one that arrives while idle, produces no `req_ack` or `req_retry`.
- R11: While busy, a pending replace is not accepted. It is accepted on the first edge after the edge that raises `free_valid`, and it is then reported with its own address.
- R12: When several events arrive in the same cycle, the acknowledge takes precedence over data, data over requests, and requests over probes. An event that loses is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| repl_valid | input | 1 | Replace request for a cache line |
| repl_ready | output | 1 | Tracker idle; replace is accepted this edge |
| repl_state | input | 3 | Coherence state of the replaced line |
| repl_addr | input | ADDR_W | Replaced line address |
| repl_data | input | DATA_W | Replaced line data |
| repl_dirty | input | 1 | Replaced line dirty bit |
| req_valid | input | 1 | Upper-level request strobe |
| req_cancel | input | 1 | 0 victim request, 1 cancel |
| req_addr | input | ADDR_W | Request address |
| req_src | input | SRC_W | Requestor identifier |
| dat_valid | input | 1 | Victim data arrival |
| dat_addr | input | ADDR_W | Victim data address |
| dat_data | input | DATA_W | Victim data |
| dat_dirty | input | 1 | Victim data dirty bit |
| ack_valid | input | 1 | Memory writeback acknowledge |
| ack_addr | input | ADDR_W | Acknowledge address |
| prb_valid | input | 1 | Probe-invalidate strobe |
| prb_addr | input | ADDR_W | Probe address |
| vreq_valid | output | 1 | Dirty-victim request to directory |
| vreq_addr | output | ADDR_W | Dirty-victim request address |
| wb_valid | output | 1 | Writeback data strobe |
| wb_addr | output | ADDR_W | Writeback address |
| wb_data | output | DATA_W | Writeback data |
| wb_dirty | output | 1 | Writeback dirty bit |
| wb_shared | output | 1 | Writeback shared flag |
| wb_cstate | output | 3 | Writeback coherence state code |
| mcancel_valid | output | 1 | Cancel-to-memory strobe |
| mcancel_addr | output | ADDR_W | Cancel address |
| unblock_valid | output | 1 | Unblock to directory |
| req_ack | output | 1 | Victim request acknowledged |
| req_retry | output | 1 | Request must be retried |
| free_valid | output | 1 | Buffer freed |

## Verification
The bench builds the block with a 16-bit address, 32-bit data, 4-bit requestor identifiers and an own identifier of 15. The own identifier is distinct from every requestor the bench uses. This makes a cancel from a stale source observable as a retry. The 32-bit data lets every writeback be told apart, so the bench can see whether the buffered copy or the late victim's copy reached memory. A single tracked line, with a second address kept for mismatch and held-replace cases, reaches every race path in a few dozen cycles.

// File: rtl/wbt_pkg.sv
package wbt_pkg;

  typedef enum logic [2:0] {
    LS_INV = 3'd0,
    LS_SHR = 3'd1,
    LS_EXC = 3'd2,
    LS_OWN = 3'd3,
    LS_MOD = 3'd4
  } line_st_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_ACK,
    ST_LATE_VIC,
    ST_DROP_DATA,
    ST_REFILL,
    ST_REFILL_ACKED,
    ST_CANCELLED
  } trk_st_t;

  typedef struct packed {
    logic alloc;
    logic copy;
    logic set_from;
    logic reset_from;
    logic vreq;
    logic wb_buf;
    logic wb_new;
    logic cancel;
    logic unblock;
    logic ack;
    logic retry;
    logic free;
  } act_t;

endpackage

// File: rtl/wbt_ctrl.sv
module wbt_ctrl
  import wbt_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    repl_fire,
  input  logic    repl_is_dirty_line,
  input  logic    ack_hit,
  input  logic    dat_hit,
  input  logic    req_hit,
  input  logic    req_is_cancel,
  input  logic    src_match,
  input  logic    prb_hit,
  output trk_st_t state,
  output logic    idle,
  output act_t    act
);

  trk_st_t nxt;

  always_comb begin
    act = '0;
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (repl_fire && repl_is_dirty_line) begin
          act.alloc = 1'b1;
          act.vreq  = 1'b1;
          nxt       = ST_WAIT_ACK;
        end
      end
      ST_WAIT_ACK: begin
        if (ack_hit) begin
          act.wb_buf = 1'b1;
          act.free   = 1'b1;
          nxt        = ST_IDLE;
        end else if (req_hit && !req_is_cancel) begin
          act.ack      = 1'b1;
          act.set_from = 1'b1;
          nxt          = ST_LATE_VIC;
        end else if (req_hit) begin
          act.retry = 1'b1;
        end else if (prb_hit) begin
          act.cancel = 1'b1;
          nxt        = ST_CANCELLED;
        end
      end
      ST_LATE_VIC: begin
        if (ack_hit) begin
          act.wb_buf = 1'b1;
          nxt        = ST_DROP_DATA;
        end else if (dat_hit) begin
          act.unblock    = 1'b1;
          act.reset_from = 1'b1;
          nxt            = ST_WAIT_ACK;
        end else if (req_hit && req_is_cancel && src_match) begin
          act.unblock    = 1'b1;
          act.reset_from = 1'b1;
          nxt            = ST_WAIT_ACK;
        end else if (req_hit) begin
          act.retry = 1'b1;
        end else if (prb_hit) begin
          nxt = ST_REFILL;
        end
      end
      ST_DROP_DATA: begin
        if (dat_hit) begin
          act.unblock = 1'b1;
          act.free    = 1'b1;
          nxt         = ST_IDLE;
        end else if (req_hit) begin
          act.retry = 1'b1;
        end
      end
      ST_REFILL: begin
        if (ack_hit) begin
          nxt = ST_REFILL_ACKED;
        end else if (dat_hit) begin
          act.copy       = 1'b1;
          act.unblock    = 1'b1;
          act.reset_from = 1'b1;
          nxt            = ST_WAIT_ACK;
        end else if (req_hit) begin
          act.retry = 1'b1;
        end
      end
      ST_REFILL_ACKED: begin
        if (dat_hit) begin
          act.wb_new  = 1'b1;
          act.unblock = 1'b1;
          act.free    = 1'b1;
          nxt         = ST_IDLE;
        end else if (req_hit) begin
          act.retry = 1'b1;
        end
      end
      ST_CANCELLED: begin
        if (ack_hit) begin
          act.free = 1'b1;
          nxt      = ST_IDLE;
        end else if (req_hit) begin
          act.retry = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  assign idle = (state == ST_IDLE);

  // R5: the buffer is freed only on a path that ends in idle
  a_r5_free_to_idle: assert property (@(posedge clk) disable iff (rst)
    act.free |=> (state == ST_IDLE));

  // R2: a dirty-victim request always starts a busy period
  a_r2_vreq_busy: assert property (@(posedge clk) disable iff (rst)
    act.vreq |=> (state == ST_WAIT_ACK));

endmodule

// File: rtl/wbt_store.sv
module wbt_store
  import wbt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SRC_W  = 4,
  parameter logic [SRC_W-1:0] SELF_ID = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  act_t              act,
  input  logic              idle,
  input  logic [ADDR_W-1:0] repl_addr,
  input  logic [DATA_W-1:0] repl_data,
  input  logic              repl_dirty,
  input  logic              repl_owned,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [DATA_W-1:0] dat_data,
  input  logic              dat_dirty,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_dirty,
  output logic              buf_shared,
  output logic [SRC_W-1:0]  buf_from
);

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_addr   <= '0;
      buf_data   <= '0;
      buf_dirty  <= 1'b0;
      buf_shared <= 1'b0;
      buf_from   <= SELF_ID;
    end else begin
      if (act.alloc) begin
        buf_addr   <= repl_addr;
        buf_data   <= repl_data;
        buf_dirty  <= repl_dirty;
        buf_shared <= repl_owned;
        buf_from   <= SELF_ID;
      end
      if (act.copy) begin
        buf_data  <= dat_data;
        buf_dirty <= dat_dirty;
      end
      if (act.set_from)   buf_from <= req_src;
      if (act.reset_from) buf_from <= SELF_ID;
    end
  end

  // R2: the buffer is only loaded while the tracker is idle
  a_r2_alloc_idle: assert property (@(posedge clk) disable iff (rst)
    act.alloc |-> idle);

  // R11: a busy buffer keeps its address until it is freed
  a_r11_addr_held: assert property (@(posedge clk) disable iff (rst)
    (!idle && !act.alloc) |=> $stable(buf_addr));

endmodule

// File: rtl/wbt_emit.sv
module wbt_emit
  import wbt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  act_t              act,
  input  logic [ADDR_W-1:0] repl_addr,
  input  logic [ADDR_W-1:0] buf_addr,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              buf_dirty,
  input  logic              buf_shared,
  input  logic [DATA_W-1:0] dat_data,
  input  logic              dat_dirty,
  output logic              vreq_valid,
  output logic [ADDR_W-1:0] vreq_addr,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data,
  output logic              wb_dirty,
  output logic              wb_shared,
  output logic              mcancel_valid,
  output logic [ADDR_W-1:0] mcancel_addr,
  output logic              unblock_valid,
  output logic              req_ack,
  output logic              req_retry,
  output logic              free_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vreq_valid    <= 1'b0;
      wb_valid      <= 1'b0;
      mcancel_valid <= 1'b0;
      unblock_valid <= 1'b0;
      req_ack       <= 1'b0;
      req_retry     <= 1'b0;
      free_valid    <= 1'b0;
      vreq_addr     <= '0;
      wb_addr       <= '0;
      wb_data       <= '0;
      wb_dirty      <= 1'b0;
      wb_shared     <= 1'b0;
      mcancel_addr  <= '0;
    end else begin
      vreq_valid    <= act.vreq;
      wb_valid      <= act.wb_buf | act.wb_new;
      mcancel_valid <= act.cancel;
      unblock_valid <= act.unblock;
      req_ack       <= act.ack;
      req_retry     <= act.retry;
      free_valid    <= act.free;
      if (act.vreq) vreq_addr <= repl_addr;
      if (act.wb_buf || act.wb_new) begin
        wb_addr   <= buf_addr;
        wb_data   <= act.wb_new ? dat_data  : buf_data;
        wb_dirty  <= act.wb_new ? dat_dirty : buf_dirty;
        wb_shared <= buf_shared;
      end
      if (act.cancel) mcancel_addr <= buf_addr;
    end
  end

  // R10: a request is either acknowledged or retried, never both
  a_r10_ack_or_retry: assert property (@(posedge clk) disable iff (rst)
    $onehot0({req_ack, req_retry}));

  // R8: a cancelled writeback never emits data in the same cycle
  a_r8_cancel_no_wb: assert property (@(posedge clk) disable iff (rst)
    mcancel_valid |-> !wb_valid);

endmodule

// File: rtl/wbt_evict_tracker.sv
module wbt_evict_tracker
  import wbt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SRC_W  = 4,
  parameter logic [SRC_W-1:0] SELF_ID = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              repl_valid,
  output logic              repl_ready,
  input  logic [2:0]        repl_state,
  input  logic [ADDR_W-1:0] repl_addr,
  input  logic [DATA_W-1:0] repl_data,
  input  logic              repl_dirty,
  input  logic              req_valid,
  input  logic              req_cancel,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SRC_W-1:0]  req_src,
  input  logic              dat_valid,
  input  logic [ADDR_W-1:0] dat_addr,
  input  logic [DATA_W-1:0] dat_data,
  input  logic              dat_dirty,
  input  logic              ack_valid,
  input  logic [ADDR_W-1:0] ack_addr,
  input  logic              prb_valid,
  input  logic [ADDR_W-1:0] prb_addr,
  output logic              vreq_valid,
  output logic [ADDR_W-1:0] vreq_addr,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data,
  output logic              wb_dirty,
  output logic              wb_shared,
  output logic [2:0]        wb_cstate,
  output logic              mcancel_valid,
  output logic [ADDR_W-1:0] mcancel_addr,
  output logic              unblock_valid,
  output logic              req_ack,
  output logic              req_retry,
  output logic              free_valid
);

  trk_st_t           state;
  logic              idle;
  act_t              act;
  logic [ADDR_W-1:0] buf_addr;
  logic [DATA_W-1:0] buf_data;
  logic              buf_dirty;
  logic              buf_shared;
  logic [SRC_W-1:0]  buf_from;

  logic repl_fire, repl_owned, repl_is_dirty_line;
  logic ack_hit, dat_hit, req_hit, prb_hit, src_match;

  assign repl_fire          = repl_valid && idle;
  assign repl_owned         = (repl_state == LS_OWN);
  assign repl_is_dirty_line = repl_owned || (repl_state == LS_MOD);
  assign ack_hit            = ack_valid && !idle && (ack_addr == buf_addr);
  assign dat_hit            = dat_valid && !idle && (dat_addr == buf_addr);
  assign req_hit            = req_valid && !idle && (req_addr == buf_addr);
  assign prb_hit            = prb_valid && !idle && (prb_addr == buf_addr);
  assign src_match          = (req_src == buf_from);

  assign repl_ready = idle;
  assign wb_cstate  = LS_SHR;

  wbt_ctrl u_ctrl (
    .clk                (clk),
    .rst                (rst),
    .repl_fire          (repl_fire),
    .repl_is_dirty_line (repl_is_dirty_line),
    .ack_hit            (ack_hit),
    .dat_hit            (dat_hit),
    .req_hit            (req_hit),
    .req_is_cancel      (req_cancel),
    .src_match          (src_match),
    .prb_hit            (prb_hit),
    .state              (state),
    .idle               (idle),
    .act                (act)
  );

  wbt_store #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SRC_W   (SRC_W),
    .SELF_ID (SELF_ID)
  ) u_store (
    .clk        (clk),
    .rst        (rst),
    .act        (act),
    .idle       (idle),
    .repl_addr  (repl_addr),
    .repl_data  (repl_data),
    .repl_dirty (repl_dirty),
    .repl_owned (repl_owned),
    .req_src    (req_src),
    .dat_data   (dat_data),
    .dat_dirty  (dat_dirty),
    .buf_addr   (buf_addr),
    .buf_data   (buf_data),
    .buf_dirty  (buf_dirty),
    .buf_shared (buf_shared),
    .buf_from   (buf_from)
  );

  wbt_emit #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_emit (
    .clk           (clk),
    .rst           (rst),
    .act           (act),
    .repl_addr     (repl_addr),
    .buf_addr      (buf_addr),
    .buf_data      (buf_data),
    .buf_dirty     (buf_dirty),
    .buf_shared    (buf_shared),
    .dat_data      (dat_data),
    .dat_dirty     (dat_dirty),
    .vreq_valid    (vreq_valid),
    .vreq_addr     (vreq_addr),
    .wb_valid      (wb_valid),
    .wb_addr       (wb_addr),
    .wb_data       (wb_data),
    .wb_dirty      (wb_dirty),
    .wb_shared     (wb_shared),
    .mcancel_valid (mcancel_valid),
    .mcancel_addr  (mcancel_addr),
    .unblock_valid (unblock_valid),
    .req_ack       (req_ack),
    .req_retry     (req_retry),
    .free_valid    (free_valid)
  );

  // R4: a freed buffer leaves the tracker ready in the same cycle
  a_r4_free_ready: assert property (@(posedge clk) disable iff (rst)
    free_valid |-> repl_ready);

  // R2: a victim request is issued only as the tracker turns busy
  a_r2_vreq_not_ready: assert property (@(posedge clk) disable iff (rst)
    vreq_valid |-> !repl_ready);

  // R11: no victim request can follow a cycle in which the tracker was busy
  a_r11_busy_no_vreq: assert property (@(posedge clk) disable iff (rst)
    !repl_ready |=> !vreq_valid);

endmodule

// File: tb/wbt_evict_tracker_tb.sv
module wbt_evict_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int SRC_W  = 4;
  localparam logic [SRC_W-1:0] SELF = 4'hF;

  localparam logic [ADDR_W-1:0] LA = 16'h1A2C;
  localparam logic [ADDR_W-1:0] LB = 16'h0B7E;

  localparam logic [3:0] EV_NONE = 4'd0, EV_RPL_M = 4'd1, EV_RPL_O = 4'd2,
                         EV_RPL_E = 4'd3, EV_VIC = 4'd4, EV_CAN = 4'd5,
                         EV_DATA = 4'd6, EV_ACK = 4'd7, EV_PRB = 4'd8;

  // flag order: vreq ack retry cancel unblock wb free ready
  localparam logic [7:0] F_VREQ = 8'h80, F_ACK = 8'h40, F_RET = 8'h20,
                         F_CAN = 8'h10, F_UNB = 8'h08, F_WB = 8'h04,
                         F_FREE = 8'h02, F_RDY = 8'h01;

  typedef struct packed {
    logic [23:0]       tag;
    logic [3:0]        ev;
    logic [SRC_W-1:0]  src;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              dirty;
    logic [7:0]        flags;
    logic [DATA_W-1:0] xdata;
    logic              xdirty;
    logic              xshared;
  } vec_t;

  function automatic vec_t v(logic [23:0] tag, logic [3:0] ev, logic [SRC_W-1:0] src,
                             logic [ADDR_W-1:0] addr, logic [DATA_W-1:0] data, logic dirty,
                             logic [7:0] flags, logic [DATA_W-1:0] xdata, logic xdirty,
                             logic xshared);
    vec_t r;
    r.tag = tag; r.ev = ev; r.src = src; r.addr = addr; r.data = data; r.dirty = dirty;
    r.flags = flags; r.xdata = xdata; r.xdirty = xdirty; r.xshared = xshared;
    return r;
  endfunction

  localparam int NV = 33;
  localparam vec_t TBL [NV] = '{
    v("R2 ", EV_RPL_M, 4'd0, LA, 32'h1111_0001, 1'b1, F_VREQ, 32'h0, 1'b0, 1'b0),
    v("R4 ", EV_ACK,   4'd0, LA, 32'h0,         1'b0, F_WB|F_FREE|F_RDY, 32'h1111_0001, 1'b1, 1'b0),
    v("R2 ", EV_RPL_O, 4'd0, LA, 32'h2222_0002, 1'b0, F_VREQ, 32'h0, 1'b0, 1'b0),
    v("R4 ", EV_ACK,   4'd0, LA, 32'h0,         1'b0, F_WB|F_FREE|F_RDY, 32'h2222_0002, 1'b0, 1'b1),
    v("R3 ", EV_RPL_E, 4'd0, LA, 32'h5555_0005, 1'b1, F_RDY, 32'h0, 1'b0, 1'b0),
    v("R2 ", EV_RPL_M, 4'd0, LA, 32'h3333_0003, 1'b1, F_VREQ, 32'h0, 1'b0, 1'b0),
    v("R10", EV_VIC,   4'd2, LB, 32'h0,         1'b0, 8'h00, 32'h0, 1'b0, 1'b0),
    v("R5 ", EV_VIC,   4'd2, LA, 32'h0,         1'b0, F_ACK, 32'h0, 1'b0, 1'b0),
    v("R6 ", EV_CAN,   4'd5, LA, 32'h0,         1'b0, F_RET, 32'h0, 1'b0, 1'b0),
    v("R6 ", EV_CAN,   4'd2, LA, 32'h0,         1'b0, F_UNB, 32'h0, 1'b0, 1'b0),
    v("R5 ", EV_VIC,   4'd3, LA, 32'h0,         1'b0, F_ACK, 32'h0, 1'b0, 1'b0),
    v("R6 ", EV_DATA,  4'd0, LA, 32'h9999_0009, 1'b0, F_UNB, 32'h0, 1'b0, 1'b0),
    v("R5 ", EV_VIC,   4'd3, LA, 32'h0,         1'b0, F_ACK, 32'h0, 1'b0, 1'b0),
    v("R5 ", EV_ACK,   4'd0, LA, 32'h0,         1'b0, F_WB, 32'h3333_0003, 1'b1, 1'b0),
    v("R10", EV_VIC,   4'd3, LA, 32'h0,         1'b0, F_RET, 32'h0, 1'b0, 1'b0),
    v("R5 ", EV_DATA,  4'd0, LA, 32'h9999_0009, 1'b0, F_UNB|F_FREE|F_RDY, 32'h0, 1'b0, 1'b0),
    v("R2 ", EV_RPL_O, 4'd0, LA, 32'h4444_0004, 1'b1, F_VREQ, 32'h0, 1'b0, 1'b0),
    v("R5 ", EV_VIC,   4'd1, LA, 32'h0,         1'b0, F_ACK, 32'h0, 1'b0, 1'b0),
    v("R7 ", EV_PRB,   4'd0, LA, 32'h0,         1'b0, 8'h00, 32'h0, 1'b0, 1'b0),
    v("R7 ", EV_DATA,  4'd0, LA, 32'h6666_0005, 1'b0, F_UNB, 32'h0, 1'b0, 1'b0),
    v("R7 ", EV_ACK,   4'd0, LA, 32'h0,         1'b0, F_WB|F_FREE|F_RDY, 32'h6666_0005, 1'b0, 1'b1),
    v("R2 ", EV_RPL_M, 4'd0, LA, 32'h7777_0006, 1'b1, F_VREQ, 32'h0, 1'b0, 1'b0),
    v("R5 ", EV_VIC,   4'd1, LA, 32'h0,         1'b0, F_ACK, 32'h0, 1'b0, 1'b0),
    v("R7 ", EV_PRB,   4'd0, LA, 32'h0,         1'b0, 8'h00, 32'h0, 1'b0, 1'b0),
    v("R7 ", EV_ACK,   4'd0, LA, 32'h0,         1'b0, 8'h00, 32'h0, 1'b0, 1'b0),
    v("R10", EV_VIC,   4'd1, LA, 32'h0,         1'b0, F_RET, 32'h0, 1'b0, 1'b0),
    v("R7 ", EV_DATA,  4'd0, LA, 32'h8888_0007, 1'b1, F_WB|F_UNB|F_FREE|F_RDY, 32'h8888_0007, 1'b1, 1'b0),
    v("R2 ", EV_RPL_M, 4'd0, LA, 32'hAAAA_0008, 1'b1, F_VREQ, 32'h0, 1'b0, 1'b0),
    v("R8 ", EV_PRB,   4'd0, LA, 32'h0,         1'b0, F_CAN, 32'h0, 1'b0, 1'b0),
    v("R8 ", EV_VIC,   4'd1, LA, 32'h0,         1'b0, F_RET, 32'h0, 1'b0, 1'b0),
    v("R8 ", EV_DATA,  4'd0, LA, 32'hBBBB_0009, 1'b1, 8'h00, 32'h0, 1'b0, 1'b0),
    v("R8 ", EV_ACK,   4'd0, LA, 32'h0,         1'b0, F_FREE|F_RDY, 32'h0, 1'b0, 1'b0),
    v("R10", EV_VIC,   4'd1, LA, 32'h0,         1'b0, F_RDY, 32'h0, 1'b0, 1'b0)
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              repl_valid = 1'b0, repl_dirty = 1'b0;
  logic              repl_ready;
  logic [2:0]        repl_state = 3'd0;
  logic [ADDR_W-1:0] repl_addr = '0;
  logic [DATA_W-1:0] repl_data = '0;
  logic              req_valid = 1'b0, req_cancel = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [SRC_W-1:0]  req_src = '0;
  logic              dat_valid = 1'b0, dat_dirty = 1'b0;
  logic [ADDR_W-1:0] dat_addr = '0;
  logic [DATA_W-1:0] dat_data = '0;
  logic              ack_valid = 1'b0, prb_valid = 1'b0;
  logic [ADDR_W-1:0] ack_addr = '0, prb_addr = '0;
  logic              vreq_valid, wb_valid, wb_dirty, wb_shared;
  logic              mcancel_valid, unblock_valid, req_ack, req_retry, free_valid;
  logic [ADDR_W-1:0] vreq_addr, wb_addr, mcancel_addr;
  logic [DATA_W-1:0] wb_data;
  logic [2:0]        wb_cstate;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wbt_evict_tracker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_W(SRC_W), .SELF_ID(SELF)
  ) u_dut (
    .clk(clk), .rst(rst),
    .repl_valid(repl_valid), .repl_ready(repl_ready), .repl_state(repl_state),
    .repl_addr(repl_addr), .repl_data(repl_data), .repl_dirty(repl_dirty),
    .req_valid(req_valid), .req_cancel(req_cancel), .req_addr(req_addr), .req_src(req_src),
    .dat_valid(dat_valid), .dat_addr(dat_addr), .dat_data(dat_data), .dat_dirty(dat_dirty),
    .ack_valid(ack_valid), .ack_addr(ack_addr), .prb_valid(prb_valid), .prb_addr(prb_addr),
    .vreq_valid(vreq_valid), .vreq_addr(vreq_addr),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data), .wb_dirty(wb_dirty),
    .wb_shared(wb_shared), .wb_cstate(wb_cstate),
    .mcancel_valid(mcancel_valid), .mcancel_addr(mcancel_addr),
    .unblock_valid(unblock_valid), .req_ack(req_ack), .req_retry(req_retry),
    .free_valid(free_valid)
  );

  function automatic logic [7:0] got_flags();
    return {vreq_valid, req_ack, req_retry, mcancel_valid, unblock_valid,
            wb_valid, free_valid, repl_ready};
  endfunction

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic clear_inputs();
    repl_valid = 1'b0; req_valid = 1'b0; dat_valid = 1'b0;
    ack_valid = 1'b0; prb_valid = 1'b0; req_cancel = 1'b0;
  endtask

  task automatic drive(vec_t t);
    clear_inputs();
    case (t.ev)
      EV_RPL_M, EV_RPL_O, EV_RPL_E: begin
        repl_valid = 1'b1;
        repl_state = (t.ev == EV_RPL_M) ? 3'd4 : (t.ev == EV_RPL_O) ? 3'd3 : 3'd2;
        repl_addr = t.addr; repl_data = t.data; repl_dirty = t.dirty;
      end
      EV_VIC, EV_CAN: begin
        req_valid = 1'b1; req_cancel = (t.ev == EV_CAN);
        req_addr = t.addr; req_src = t.src;
      end
      EV_DATA: begin
        dat_valid = 1'b1; dat_addr = t.addr; dat_data = t.data; dat_dirty = t.dirty;
      end
      EV_ACK: begin ack_valid = 1'b1; ack_addr = t.addr; end
      EV_PRB: begin prb_valid = 1'b1; prb_addr = t.addr; end
      default: ;
    endcase
  endtask

  task automatic check_vec(vec_t t);
    string tg;
    tg = $sformatf("%s", t.tag);
    chk(tg, "flags", 64'(got_flags()), 64'(t.flags));
    if (t.flags & F_WB) begin
      chk(tg, "wb_data", 64'(wb_data), 64'(t.xdata));
      chk(tg, "wb_dirty/shared", 64'({wb_dirty, wb_shared}), 64'({t.xdirty, t.xshared}));
      chk("R9", "wb_cstate", 64'(wb_cstate), 64'(3'd1));
      chk("R9", "wb_addr", 64'(wb_addr), 64'(LA));
    end
    if (t.flags & F_VREQ) chk(tg, "vreq_addr", 64'(vreq_addr), 64'(t.addr));
    if (t.flags & F_CAN)  chk(tg, "mcancel_addr", 64'(mcancel_addr), 64'(LA));
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    chk("R1", "reset flags", 64'(got_flags()), 64'(F_RDY));

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      step();
      check_vec(TBL[i]);
    end

    // R11: held replace while busy
    @(negedge clk);
    drive(v("R11", EV_RPL_M, 4'd0, LA, 32'hC0C0_0001, 1'b1, 8'h00, 32'h0, 1'b0, 1'b0));
    step();
    chk("R11", "first vreq", 64'(got_flags()), 64'(F_VREQ));
    @(negedge clk);
    repl_valid = 1'b1; repl_state = 3'd3; repl_addr = LB;
    repl_data = 32'hD0D0_0002; repl_dirty = 1'b1;
    step();
    chk("R11", "held no accept", 64'(got_flags()), 64'(8'h00));
    @(negedge clk);
    ack_valid = 1'b1; ack_addr = LA;
    step();
    chk("R11", "free while held", 64'(got_flags()), 64'(F_WB|F_FREE|F_RDY));
    @(negedge clk);
    ack_valid = 1'b0;
    step();
    chk("R11", "held accepted", 64'(got_flags()), 64'(F_VREQ));
    chk("R11", "held addr", 64'(vreq_addr), 64'(LB));
    @(negedge clk);
    clear_inputs();
    ack_valid = 1'b1; ack_addr = LB;
    step();
    chk("R11", "held wb data", 64'(wb_data), 64'(32'hD0D0_0002));
    chk("R11", "held wb shared", 64'(wb_shared), 64'(1'b1));

    // R12: acknowledge beats data in the same cycle
    @(negedge clk);
    drive(v("R12", EV_RPL_M, 4'd0, LA, 32'hE0E0_0003, 1'b1, 8'h00, 32'h0, 1'b0, 1'b0));
    step();
    @(negedge clk);
    drive(v("R12", EV_VIC, 4'd6, LA, 32'h0, 1'b0, 8'h00, 32'h0, 1'b0, 1'b0));
    step();
    chk("R12", "late victim ack", 64'(got_flags()), 64'(F_ACK));
    @(negedge clk);
    clear_inputs();
    ack_valid = 1'b1; ack_addr = LA;
    dat_valid = 1'b1; dat_addr = LA; dat_data = 32'hF0F0_0004; dat_dirty = 1'b1;
    step();
    chk("R12", "ack wins", 64'(got_flags()), 64'(F_WB));
    chk("R12", "ack wins data", 64'(wb_data), 64'(32'hE0E0_0003));
    @(negedge clk);
    clear_inputs();
    dat_valid = 1'b1; dat_addr = LA; dat_data = 32'hF0F0_0004;
    step();
    chk("R12", "data dropped after", 64'(got_flags()), 64'(F_UNB|F_FREE|F_RDY));
    @(negedge clk);
    clear_inputs();
    step();
    chk("R1", "quiet idle", 64'(got_flags()), 64'(F_RDY));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule